// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is an 8-bit, full-duplex synchronous serial port. Software loads a byte into a transmit holding register. The byte moves into a shift register and goes out on `sdo`. In the same transfer, the byte arriving on `sdi` is assembled and placed in a receive holding register. Every transfer is exactly eight data bits, with no framing bits around them.

The transfer clock has two possible sources. When the block is the clock master, it generates the clock with an internal bit-rate divider, fed from one of four prescaled system-clock sources, and drives it out on `sclk_out`. When the block is a slave, the clock arrives on `sclk_in`, and the block samples it in the system clock domain. The system clock must run at least four times faster than that external clock.

Several options are selectable:
- the clock idle level and active edges;
- the bit order;
- which event raises the transmit interrupt;
- a continuous-receive option, in which reading the receive buffer starts the next reception without a new transmit byte.

A byte that completes while the receive buffer is still unread overwrites it. It sets an overrun flag and raises no receive interrupt.

Top module: `ssio_xcvr`

## Requirements
- R1: A transfer moves exactly 8 bits, one per clock period. It shifts the transmit byte out on `sdo` and captures 8 bits from `sdi` into `rx_rdata`. Exactly 8 leading edges occur per transfer.
- R2: With `ext_clk`=0, consecutive leading edges are 2·(`div_n`+1) source ticks apart. The tick source is set by `fi_sel`: 0 = every system clock, 1 = every PRE_A clocks, 2 = every PRE_B clocks, 3 = each `alt_tick` pulse.
- R3: With `ext_clk`=0, the block drives the clock (`sclk_oe`=1) on `sclk_out`. With `ext_clk`=1, `sclk_oe`=0 and the transfer is timed by edges on `sclk_in`.
- R4: A transfer starts only while `tx_en`=1 and the transmit buffer holds data (`tx_empty`=0). With `ext_clk`=1, `sclk_in` must also sit at its idle level. `tx_empty` rises when the byte moves into the shift register.
- R5: Reception happens only in a transfer that started with `rx_en`=1. With `rx_en`=1 alone and an empty transmit buffer (continuous mode off), no transfer starts.
- R6: With `tx_irq_sel`=0, `tx_irq` pulses when the buffer loads the shift register, which is before the first leading edge. With `tx_irq_sel`=1, it pulses at the last trailing edge.
- R7: When a received byte is stored and the buffer was empty, `rx_irq` pulses once and `rx_full` becomes 1. Asserting `rx_rd` clears `rx_full`.
- R8: A byte completing while `rx_full`=1 overwrites `rx_rdata`, sets `overrun` and gives no `rx_irq`. `rx_rd` clears `overrun`.
- R9: The idle level is `sclk`=1 when `clk_pol`=0, and `sclk`=0 when `clk_pol`=1. Data changes on the edge leaving idle and is sampled on the edge returning to idle.
- R10: `msb_first`=0 shifts bit 0 first, and `msb_first`=1 shifts bit 7 first. The setting applies to both directions.
- R11: With `cont_rx`=1 and `rx_en`=1, an `rx_rd` starts the next transfer with no transmit write. That transfer sends all ones and raises no `tx_irq`.
- R12: After reset, the block shows `tx_empty`=1, `rx_full`=0, `overrun`=0, `sdo`=1, `sclk_out`=1 and `sclk_oe`=1 (with `clk_pol`=0, `ext_clk`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fi_sel | input | 2 | Divider tick source select |
| alt_tick | input | 1 | One-cycle tick from a separate clock source |
| div_n | input | 8 | Bit-rate divider value n |
| ext_clk | input | 1 | 1 selects external transfer clock |
| clk_pol | input | 1 | Clock polarity select |
| msb_first | input | 1 | Bit order select |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_irq_sel | input | 1 | Transmit interrupt cause select |
| cont_rx | input | 1 | Continuous receive enable |
| tx_wr | input | 1 | Write strobe for transmit buffer |
| tx_wdata | input | 8 | Transmit byte |
| rx_rd | input | 1 | Read strobe for receive buffer |
| rx_rdata | output | 8 | Receive buffer contents |
| tx_empty | output | 1 | Transmit buffer empty flag |
| rx_full | output | 1 | Receive buffer holds unread data |
| overrun | output | 1 | Overrun error flag |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Generated transfer clock |
| sclk_oe | output | 1 | Clock output enable |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: 8 data bits, an 8-bit divider, prescalers of 8 and 32, and a two-stage synchroniser.

Small divider values, together with an `alt_tick` that the bench pulses every fourth clock, let all four tick sources be measured within a few hundred cycles. At those settings the divider spacing formula can be checked exactly from the leading-edge intervals.

In slave mode, the bench drives the external clock with a 12-cycle period. This keeps the synchroniser delay well inside each half period, so both the idle-level start gate and the data paths can be checked.

// File: rtl/ssio_pkg.sv
package ssio_pkg;
   typedef enum logic [1:0] {
      FI_DIV1 = 2'd0,
      FI_DIVA = 2'd1,
      FI_DIVB = 2'd2,
      FI_ALT  = 2'd3
   } fi_sel_e;
endpackage

// File: rtl/ssio_fi_gen.sv
// Produces the tick that advances the bit-rate divider.
module ssio_fi_gen
   import ssio_pkg::*;
#(
   parameter int PRE_A = 8,
   parameter int PRE_B = 32
)(
   input  logic    clk,
   input  logic    rst_n,
   input  fi_sel_e sel,
   input  logic    alt_tick,
   output logic    tick
);
   logic [1:0] pre_tick;

   for (genvar g = 0; g < 2; g++) begin : g_pre
      localparam int P  = (g == 0) ? PRE_A : PRE_B;
      localparam int CW = $clog2(P);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                cnt <= '0;
         else if (cnt == CW'(P-1))  cnt <= '0;
         else                       cnt <= cnt + 1'b1;
      end
      assign pre_tick[g] = (cnt == CW'(P-1));
   end

   always_comb begin
      case (sel)
         FI_DIV1: tick = 1'b1;
         FI_DIVA: tick = pre_tick[0];
         FI_DIVB: tick = pre_tick[1];
         default: tick = alt_tick;
      endcase
   end
endmodule

// File: rtl/ssio_brg.sv
// Internal transfer clock: toggles every (div_n+1) ticks while running.
module ssio_brg #(
   parameter int DIV_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             fi_tick,
   input  logic             idle_lvl,
   input  logic [DIV_W-1:0] div_n,
   output logic             lvl,
   output logic             edge_o
);
   logic [DIV_W-1:0] cnt;

   assign edge_o = run && fi_tick && (cnt == div_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         lvl <= 1'b1;
      end else if (!run) begin
         cnt <= '0;
         lvl <= idle_lvl;
      end else if (fi_tick) begin
         if (cnt == div_n) begin
            cnt <= '0;
            lvl <= ~lvl;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ssio_clk_sync.sv
// Multi-stage synchroniser with change detection for the external clock.
module ssio_clk_sync #(
   parameter int STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic chg
);
   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-1:0], d};
   end

   assign q   = sh[STAGES-1];
   assign chg = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/ssio_xcvr.sv
module ssio_xcvr
   import ssio_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter int PRE_A       = 8,
   parameter int PRE_B       = 32,
   parameter int SYNC_STAGES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        fi_sel,
   input  logic              alt_tick,
   input  logic [DIV_W-1:0]  div_n,
   input  logic              ext_clk,
   input  logic              clk_pol,
   input  logic              msb_first,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic              tx_irq_sel,
   input  logic              cont_rx,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_wdata,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_rdata,
   output logic              tx_empty,
   output logic              rx_full,
   output logic              overrun,
   output logic              tx_irq,
   output logic              rx_irq,
   input  logic              sclk_in,
   output logic              sclk_out,
   output logic              sclk_oe,
   output logic              sdo,
   input  logic              sdi
);
   localparam int BCW = $clog2(DATA_W);

   if (DATA_W < 2)      begin : g_bad_w   $error("DATA_W must be at least 2");    end
   if (DIV_W < 1)       begin : g_bad_d   $error("DIV_W must be at least 1");     end
   if (PRE_A < 2)       begin : g_bad_a   $error("PRE_A must be at least 2");     end
   if (PRE_B < 2)       begin : g_bad_b   $error("PRE_B must be at least 2");     end
   if (SYNC_STAGES < 2) begin : g_bad_s   $error("SYNC_STAGES must be >= 2");     end

   logic idle_lvl;
   assign idle_lvl = ~clk_pol;

   logic fi_tick;
   ssio_fi_gen #(.PRE_A(PRE_A), .PRE_B(PRE_B)) u_fi (
      .clk(clk), .rst_n(rst_n), .sel(fi_sel_e'(fi_sel)),
      .alt_tick(alt_tick), .tick(fi_tick)
   );

   logic busy, tx_act, rx_act;
   logic brg_lvl, brg_edge;
   ssio_brg #(.DIV_W(DIV_W)) u_brg (
      .clk(clk), .rst_n(rst_n), .run(busy && !ext_clk), .fi_tick(fi_tick),
      .idle_lvl(idle_lvl), .div_n(div_n), .lvl(brg_lvl), .edge_o(brg_edge)
   );

   logic ext_lvl, ext_chg;
   ssio_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sclk_in), .q(ext_lvl), .chg(ext_chg)
   );

   assign sclk_out = brg_lvl;
   assign sclk_oe  = ~ext_clk;

   // Edge classification: leading leaves idle, trailing returns to it.
   logic sclk_edge, lead, trail;
   assign sclk_edge = busy && (ext_clk ? ext_chg : brg_edge);
   assign lead      = sclk_edge && (ext_clk ? (ext_lvl != idle_lvl) : (brg_lvl == idle_lvl));
   assign trail     = sclk_edge && !lead;

   logic [DATA_W-1:0] tx_buf, tx_sh, rx_sh, rx_next;
   logic [BCW-1:0]    bit_cnt;
   logic              rx_arm;
   logic              start_tx, start, done, store_ok;

   assign start_tx = ~tx_empty;
   assign start    = !busy && tx_en && (start_tx || (rx_arm && rx_en))
                     && (!ext_clk || (ext_lvl == idle_lvl));
   assign done     = trail && (bit_cnt == BCW'(DATA_W-1));
   assign rx_next  = msb_first ? {rx_sh[DATA_W-2:0], sdi} : {sdi, rx_sh[DATA_W-1:1]};
   assign store_ok = !rx_full || rx_rd;

   // Shift core
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         tx_act  <= 1'b0;
         rx_act  <= 1'b0;
         bit_cnt <= '0;
         tx_sh   <= '1;
         rx_sh   <= '0;
         sdo     <= 1'b1;
      end else if (start) begin
         busy    <= 1'b1;
         tx_act  <= start_tx;
         rx_act  <= rx_en;
         bit_cnt <= '0;
         tx_sh   <= start_tx ? tx_buf : '1;
      end else begin
         if (lead) begin
            sdo   <= msb_first ? tx_sh[DATA_W-1] : tx_sh[0];
            tx_sh <= msb_first ? {tx_sh[DATA_W-2:0], 1'b1} : {1'b1, tx_sh[DATA_W-1:1]};
         end
         if (trail) begin
            rx_sh   <= rx_next;
            bit_cnt <= bit_cnt + 1'b1;
         end
         if (done) busy <= 1'b0;
      end
   end

   // Continuous-receive rearm
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        rx_arm <= 1'b0;
      else if (start || !cont_rx || !rx_en) rx_arm <= 1'b0;
      else if (rx_rd)                    rx_arm <= 1'b1;
   end

   // Transmit holding register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_buf   <= '0;
         tx_empty <= 1'b1;
      end else if (tx_wr) begin
         tx_buf   <= tx_wdata;
         tx_empty <= 1'b0;
      end else if (start && start_tx) begin
         tx_empty <= 1'b1;
      end
   end

   // Receive holding register and error flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_rdata <= '0;
         rx_full  <= 1'b0;
         overrun  <= 1'b0;
      end else if (done && rx_act) begin
         rx_rdata <= rx_next;
         rx_full  <= 1'b1;
         if (!store_ok) overrun <= 1'b1;
         else if (rx_rd) overrun <= 1'b0;
      end else if (rx_rd) begin
         rx_full <= 1'b0;
         overrun <= 1'b0;
      end
   end

   // Interrupt pulses
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_irq <= 1'b0;
         rx_irq <= 1'b0;
      end else begin
         tx_irq <= (start && start_tx && !tx_irq_sel) || (done && tx_act && tx_irq_sel);
         rx_irq <= done && rx_act && store_ok;
      end
   end
endmodule

// File: rtl/ssio_xcvr_chk.sv
module ssio_xcvr_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic rx_rd,
   input logic tx_empty,
   input logic rx_full,
   input logic overrun,
   input logic rx_irq
);
   p_start_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_empty) |-> $past(tx_en));

   p_rxirq_buf_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> rx_full);

   p_rxirq_no_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> !overrun);

   p_ovr_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> !rx_irq);

   p_read_clears_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rd |=> !overrun);
endmodule

bind ssio_xcvr ssio_xcvr_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_rd(rx_rd),
   .tx_empty(tx_empty), .rx_full(rx_full), .overrun(overrun), .rx_irq(rx_irq)
);

// File: tb/ssio_xcvr_tb.sv
module ssio_xcvr_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [1:0] fi_sel = 2'd0;
   logic       alt_tick = 1'b0;
   logic [7:0] div_n = 8'd0;
   logic ext_clk = 0, clk_pol = 0, msb_first = 0, tx_en = 1, rx_en = 1;
   logic tx_irq_sel = 0, cont_rx = 0, tx_wr = 0, rx_rd = 0;
   logic [7:0] tx_wdata = 8'd0;
   logic [7:0] rx_rdata;
   logic tx_empty, rx_full, overrun, tx_irq, rx_irq;
   logic sclk_in = 1'b1, sclk_out, sclk_oe, sdo, sdi = 1'b0;

   ssio_xcvr u_dut (
      .clk(clk), .rst_n(rst_n), .fi_sel(fi_sel), .alt_tick(alt_tick), .div_n(div_n),
      .ext_clk(ext_clk), .clk_pol(clk_pol), .msb_first(msb_first), .tx_en(tx_en),
      .rx_en(rx_en), .tx_irq_sel(tx_irq_sel), .cont_rx(cont_rx), .tx_wr(tx_wr),
      .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata), .tx_empty(tx_empty),
      .rx_full(rx_full), .overrun(overrun), .tx_irq(tx_irq), .rx_irq(rx_irq),
      .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdo(sdo), .sdi(sdi)
   );

   int total = 0, bad = 0, cyc = 0;
   bit finished = 0;

   // Behavioural peer model
   logic [7:0] slave_byte = 8'h00, acc = 8'h00, got_last = 8'h00;
   logic line, prev_line = 1'b1, idle;
   int bitk = 0, lead_cnt = 0, lead_per = -1, last_lead = -1, first_lead = -1;
   int last_trail = -1, got_n = 0, txi_cnt = 0, txi_cyc = -1, rxi_cnt = 0;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic mdl_clear();
      prev_line  = ext_clk ? sclk_in : sclk_out;
      bitk = 0; lead_cnt = 0; lead_per = -1; last_lead = -1; first_lead = -1;
      last_trail = -1; txi_cnt = 0; txi_cyc = -1; rxi_cnt = 0;
   endtask

   // Compared on every falling edge of the system clock
   always @(negedge clk) begin
      cyc++;
      idle = ~clk_pol;
      line = ext_clk ? sclk_in : sclk_out;
      if (rst_n) begin
         if (line != prev_line) begin
            if (line != idle) begin
               lead_cnt++;
               if (last_lead >= 0) lead_per = cyc - last_lead;
               last_lead = cyc;
               if (first_lead < 0) first_lead = cyc;
               sdi = msb_first ? slave_byte[7-bitk] : slave_byte[bitk];
            end else begin
               if (msb_first) acc[7-bitk] = sdo; else acc[bitk] = sdo;
               bitk++;
               last_trail = cyc;
               if (bitk == 8) begin
                  got_last = acc; got_n++; bitk = 0;
               end
            end
         end
         if (tx_irq) begin txi_cnt++; txi_cyc = cyc; end
         if (rx_irq) rxi_cnt++;
         if (sclk_oe != !ext_clk) chk("R3 clock drive", sclk_oe, !ext_clk);
         if (rx_irq && overrun)   chk("R8 irq with overrun", 1, 0);
      end
      prev_line = line;
   end

   initial begin
      forever begin
         @(posedge clk); #1 alt_tick = (cyc % 4 == 0);
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_tx(input logic [7:0] b);
      @(posedge clk); #1 tx_wdata = b; tx_wr = 1'b1;
      @(posedge clk); #1 tx_wr = 1'b0;
   endtask

   task automatic rd_rx();
      @(posedge clk); #1 rx_rd = 1'b1;
      @(posedge clk); #1 rx_rd = 1'b0;
   endtask

   task automatic wait_xfer(input int n0);
      for (int i = 0; i < 3000 && got_n == n0; i++) @(negedge clk);
      chk("R1 transfer completes", got_n, n0 + 1);
      cycles(4);
   endtask

   task automatic ext_run();
      for (int i = 0; i < 8; i++) begin
         @(posedge clk); #1 sclk_in = clk_pol;
         repeat (6) @(posedge clk);
         #1 sclk_in = ~clk_pol;
         repeat (5) @(posedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL R1 watchdog act=running exp=finished");
      finish_run();
   end

   initial begin
      int n0;
      cycles(3);
      @(posedge clk); #1 rst_n = 1'b1;
      cycles(2);
      // R12 reset state
      chk("R12 tx_empty", tx_empty, 1);
      chk("R12 rx_full", rx_full, 0);
      chk("R12 overrun", overrun, 0);
      chk("R12 sclk_out", sclk_out, 1);
      chk("R12 sclk_oe", sclk_oe, 1);
      chk("R12 sdo", sdo, 1);

      // R1 / R10 lsb-first / R7 / R6 cause 0
      mdl_clear(); slave_byte = 8'h3C; n0 = got_n;
      wr_tx(8'hA5); wait_xfer(n0);
      chk("R1 sdo byte", got_last, 8'hA5);
      chk("R1 rx byte", rx_rdata, 8'h3C);
      chk("R1 eight leading edges", lead_cnt, 8);
      chk("R7 rx_full", rx_full, 1);
      chk("R7 one rx_irq", rxi_cnt, 1);
      chk("R6 one tx_irq", txi_cnt, 1);
      chk("R6 irq before first lead", int'(txi_cyc < first_lead), 1);
      rd_rx(); cycles(2);
      chk("R7 read clears full", rx_full, 0);

      // R10 msb-first, R9 polarity 1
      clk_pol = 1; msb_first = 1; cycles(3);
      chk("R9 idle low", sclk_out, 0);
      mdl_clear(); slave_byte = 8'h4D; n0 = got_n;
      wr_tx(8'h1E); wait_xfer(n0);
      chk("R10 msb sdo byte", got_last, 8'h1E);
      chk("R10 msb rx byte", rx_rdata, 8'h4D);
      chk("R9 back to idle low", sclk_out, 0);
      rd_rx();
      clk_pol = 0; msb_first = 0; cycles(3);

      // R2 rates
      div_n = 8'd2; mdl_clear(); n0 = got_n; wr_tx(8'h33); wait_xfer(n0);
      chk("R2 f1 n=2 spacing", lead_per, 6);
      rd_rx();
      div_n = 8'd0; fi_sel = 2'd1; mdl_clear(); n0 = got_n; wr_tx(8'h66); wait_xfer(n0);
      chk("R2 PRE_A spacing", lead_per, 16);
      rd_rx();
      fi_sel = 2'd2; mdl_clear(); n0 = got_n; wr_tx(8'h99); wait_xfer(n0);
      chk("R2 PRE_B spacing", lead_per, 64);
      rd_rx();
      fi_sel = 2'd3; mdl_clear(); n0 = got_n; wr_tx(8'hC3); wait_xfer(n0);
      chk("R2 alt tick spacing", lead_per, 8);
      rd_rx();
      fi_sel = 2'd0; cycles(2);

      // R6 cause 1
      tx_irq_sel = 1; mdl_clear(); n0 = got_n; wr_tx(8'h5C); wait_xfer(n0);
      chk("R6 single irq", txi_cnt, 1);
      chk("R6 irq at last trail", int'(txi_cyc >= last_trail), 1);
      tx_irq_sel = 0; rd_rx();

      // R4 transmit enable gating
      tx_en = 0; mdl_clear(); slave_byte = 8'h00;
      wr_tx(8'h55); cycles(40);
      chk("R4 no edges while disabled", lead_cnt, 0);
      chk("R4 buffer kept", tx_empty, 0);
      n0 = got_n; tx_en = 1; wait_xfer(n0);
      chk("R4 sent after enable", got_last, 8'h55);
      rd_rx();

      // R5 receive gating
      rx_en = 0; mdl_clear(); slave_byte = 8'h11; n0 = got_n;
      wr_tx(8'h77); wait_xfer(n0);
      chk("R5 tx-only byte", got_last, 8'h77);
      chk("R5 rx_full untouched", rx_full, 0);
      chk("R5 no rx_irq", rxi_cnt, 0);
      rx_en = 1; mdl_clear(); cycles(40);
      chk("R5 rx_en alone no transfer", lead_cnt, 0);

      // R8 overrun
      mdl_clear(); slave_byte = 8'h22; n0 = got_n; wr_tx(8'h01); wait_xfer(n0);
      slave_byte = 8'h33; n0 = got_n; wr_tx(8'h02); wait_xfer(n0);
      chk("R8 overrun set", overrun, 1);
      chk("R8 overwritten", rx_rdata, 8'h33);
      chk("R8 single rx_irq", rxi_cnt, 1);
      rd_rx(); cycles(1);
      chk("R8 read clears", overrun, 0);

      // R11 continuous receive
      cont_rx = 1; mdl_clear(); slave_byte = 8'h44; n0 = got_n;
      wr_tx(8'h10); wait_xfer(n0);
      chk("R11 first rx", rx_rdata, 8'h44);
      slave_byte = 8'h66; n0 = got_n;
      rd_rx(); wait_xfer(n0);
      chk("R11 ones sent", got_last, 8'hFF);
      chk("R11 rearmed rx", rx_rdata, 8'h66);
      chk("R11 no extra tx_irq", txi_cnt, 1);
      chk("R11 second rx_irq", rxi_cnt, 2);
      cont_rx = 0; cycles(1); rd_rx();

      // R3 / R4 external clock
      ext_clk = 1; sclk_in = 1; cycles(4);
      chk("R3 clock not driven", sclk_oe, 0);
      sclk_in = 0; cycles(2);
      wr_tx(8'h5A); cycles(20);
      chk("R4 ext non-idle blocks start", tx_empty, 0);
      sclk_in = 1; cycles(10);
      chk("R4 ext idle starts", tx_empty, 1);
      mdl_clear(); slave_byte = 8'h69; n0 = got_n;
      ext_run(); cycles(10);
      chk("R3 ext transfer done", got_n, n0 + 1);
      chk("R3 ext sdo byte", got_last, 8'h5A);
      chk("R3 ext rx byte", rx_rdata, 8'h69);
      chk("R1 ext eight leads", lead_cnt, 8);

      finish_run();
   end
endmodule